// File: doc/BRIEF.md
# Fault Isolation Register with Attention Classification

This block gathers hardware error events into a sticky fault register and turns the active bits into two attention outputs. One is a check-stop, which reports a fatal error. The other reports a recoverable error. Each event input sets its own fault bit, and the bit stays set until software clears it. A per-bit mask hides bits from both outputs. Two action registers give every bit a two-bit code: action0 and action1 together choose check-stop, recoverable, or no attention at all.

Software reaches the registers over a plain register bus. The bus has an address, a write strobe, a read strobe and a data word, and it decodes an eight-word window at `BASE`. Besides the direct-load offsets, the window has atomic alias offsets. One alias ANDs the write data into a register and another ORs it in. These let software clear fault bits, or set and clear mask bits, with a single write instead of a read-modify-write.

Top module: `fir_attn`

## Requirements
- R1: After reset the fault register is zero, the mask register is all ones, both action registers are zero, and both attention outputs are low.
- R2: A high bit on `evt_i` sets the matching fault bit on that clock edge. The bit stays set through later cycles until a write to offset 0 or offset 1 changes it.
- R3: A write to offset 1 ANDs the write data into the fault register, so a zero data bit clears that fault bit. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A write to offset 0 loads the fault register with the write data, ORed with any event present in that cycle. A read at offset 0 returns the fault register.
- R5: A write to offset 4 loads the mask register. A write to offset 2 ANDs the write data into the mask. A write to offset 5 ORs the write data into the mask. A read at offset 3 returns the mask.
- R6: Writes and reads at offset 6 and offset 7 load and return action register 0 and action register 1.
- R7: `chkstop_o` is high exactly when some bit is set in fault, clear in mask, clear in action0 and clear in action1. It follows register changes in the same cycle that they take effect.
- R8: `recov_o` is high exactly when some bit is set in fault, clear in mask, clear in action0 and set in action1.
- R9: A fault bit whose action0 bit is set raises neither attention output, whatever its action1 bit is. The bit stays readable in the fault register.
- R10: A read at offset 1, 2, 4 or 5, or at an address outside the window, returns zero and raises `err_o` for exactly one cycle.
- R11: Read data and `err_o` are registered. They appear in the cycle after the read strobe. Back-to-back reads return one result per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | W | Error event inputs, one per fault bit |
| addr_i | input | AW | Bus word address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Registered read data |
| err_o | output | 1 | One-cycle access-error flag for an unused read |
| chkstop_o | output | 1 | Check-stop attention |
| recov_o | output | 1 | Recoverable attention |

## Verification
An event or a write changes state at the next rising edge. The attention outputs are combinational from that state, so the bench drives a stimulus at a falling edge and checks the attentions at the following falling edge. Read results take one register stage. The driver therefore pushes each expected word and error flag into a queue when it issues the read. A monitor that saw the strobe at the rising edge pops the queue and compares the data one falling edge later. Because of this, back-to-back reads and the one-cycle error pulse line up with their requests.

// File: rtl/fir_attn.sv
module fir_attn #(
  parameter int W = 64,
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'h0800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  evt_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          err_o,
  output logic          chkstop_o,
  output logic          recov_o
);
  localparam int OW = 3;

  logic [W-1:0] fault, mask, act0, act1;
  logic [OW-1:0] off;
  logic hit, wr_hit;

  assign off    = addr_i[OW-1:0];
  assign hit    = addr_i[AW-1:OW] == BASE[AW-1:OW];
  assign wr_hit = wr_i && hit;

  always_ff @(posedge clk) begin
    if (rst) fault <= '0;
    else if (wr_hit && off == 3'd0) fault <= wdata_i | evt_i;
    else if (wr_hit && off == 3'd1) fault <= (fault & wdata_i) | evt_i;
    else fault <= fault | evt_i;
  end

  always_ff @(posedge clk) begin
    if (rst) mask <= '1;
    else if (wr_hit) begin
      case (off)
        3'd2: mask <= mask & wdata_i;
        3'd4: mask <= wdata_i;
        3'd5: mask <= mask | wdata_i;
        default: mask <= mask;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act0 <= '0;
      act1 <= '0;
    end else begin
      if (wr_hit && off == 3'd6) act0 <= wdata_i;
      if (wr_hit && off == 3'd7) act1 <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_i) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else if (!hit) begin
      rdata_o <= '0;
      err_o   <= 1'b1;
    end else begin
      err_o <= 1'b0;
      case (off)
        3'd0: rdata_o <= fault;
        3'd3: rdata_o <= mask;
        3'd6: rdata_o <= act0;
        3'd7: rdata_o <= act1;
        default: begin
          rdata_o <= '0;
          err_o   <= 1'b1;
        end
      endcase
    end
  end

  assign chkstop_o = |(fault & ~mask & ~act0 & ~act1);
  assign recov_o   = |(fault & ~mask & ~act0 & act1);
endmodule

// File: rtl/fir_attn_chk.sv
module fir_attn_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] evt,
  input logic         wr_hit,
  input logic [2:0]   off,
  input logic [W-1:0] wdata,
  input logic [W-1:0] fault,
  input logic [W-1:0] mask,
  input logic [W-1:0] act0,
  input logic [W-1:0] act1,
  input logic         rd,
  input logic [W-1:0] rdata,
  input logic         err,
  input logic         chk,
  input logic         rec
);
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((fault & $past(evt)) == $past(evt))); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(wr_hit && (off == 3'd0 || off == 3'd1)) |=> ((fault & $past(fault)) == $past(fault))); // R2
  AST_MASK_OR: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && off == 3'd5) |=> ((mask & $past(wdata)) == $past(wdata))); // R5
  AST_CS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    chk |-> (|(fault & ~mask))); // R7
  AST_A0_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((fault & ~mask & ~act0) == '0) |-> (!chk && !rec)); // R9
  AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(rd)); // R11
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    err |-> (rdata == '0)); // R10
endmodule

bind fir_attn fir_attn_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .evt(evt_i), .wr_hit(wr_hit), .off(off),
  .wdata(wdata_i), .fault(fault), .mask(mask), .act0(act0), .act1(act1),
  .rd(rd_i), .rdata(rdata_o), .err(err_o), .chk(chkstop_o), .rec(recov_o)
);

// File: tb/tb_fir_attn.sv
module tb_fir_attn;
  localparam int W = 64;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0800;

  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] evt = '0, wdata = '0;
  logic [AW-1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [W-1:0] rdata;
  logic err, chkstop, recov;

  int checks = 0, errors = 0;
  logic pend = 1'b0;
  logic [W-1:0] q_data[$];
  logic q_err[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  fir_attn #(.W(W), .AW(AW), .BASE(BASE)) dut (
    .clk(clk), .rst(rst), .evt_i(evt), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .chkstop_o(chkstop), .recov_o(recov));

  always @(posedge clk) pend <= rd;

  always @(negedge clk) begin
    if (pend && q_data.size() > 0) begin
      logic [W-1:0] ed;
      logic ee;
      string t;
      ed = q_data.pop_front();
      ee = q_err.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (rdata !== ed || err !== ee) begin
        errors++;
        $display("FAIL %s read: data %h err %0b, expected %h err %0b", t, rdata, err, ed, ee);
      end
    end else if (!pend && err !== 1'b0) begin
      errors++;
      $display("FAIL R10 err not a single pulse: got %0b expected 0", err);
    end
  end

  task automatic wr_reg(input logic [2:0] o, input logic [W-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = BASE + AW'(o); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic issue_rd(input logic [AW-1:0] a, input logic [W-1:0] ed, input logic ee, input string t);
    addr = a; rd = 1'b1;
    q_data.push_back(ed); q_err.push_back(ee); q_tag.push_back(t);
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, input logic [W-1:0] ed, input logic ee, input string t);
    @(negedge clk);
    issue_rd(a, ed, ee, t);
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [W-1:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic chk_attn(input logic ec, input logic er, input string t);
    checks++;
    if (chkstop !== ec || recov !== er) begin
      errors++;
      $display("FAIL %s attention: chkstop %0b recov %0b, expected %0b %0b", t, chkstop, recov, ec, er);
    end
  endtask

  localparam logic [W-1:0] B5 = 64'h20, B9 = 64'h200;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_attn(1'b0, 1'b0, "R1");
    rd_reg(BASE + 0, '0, 1'b0, "R1 fault");
    rd_reg(BASE + 3, '1, 1'b0, "R1 mask");
    rd_reg(BASE + 6, '0, 1'b0, "R1 act0");
    rd_reg(BASE + 7, '0, 1'b0, "R1 act1");

    pulse_evt(B5);
    chk_attn(1'b0, 1'b0, "R7 masked");
    repeat (2) @(negedge clk);
    rd_reg(BASE + 0, B5, 1'b0, "R2 sticky");

    wr_reg(3'd4, '0);
    chk_attn(1'b1, 1'b0, "R7");
    rd_reg(BASE + 3, '0, 1'b0, "R5 load");

    wr_reg(3'd7, B5);
    chk_attn(1'b0, 1'b1, "R8");
    rd_reg(BASE + 7, B5, 1'b0, "R6 act1");

    wr_reg(3'd6, B5);
    chk_attn(1'b0, 1'b0, "R9");
    rd_reg(BASE + 0, B5, 1'b0, "R9 recorded");
    rd_reg(BASE + 6, B5, 1'b0, "R6 act0");

    wr_reg(3'd6, '0);
    wr_reg(3'd7, '0);
    chk_attn(1'b1, 1'b0, "R7 again");
    wr_reg(3'd1, ~B5);
    chk_attn(1'b0, 1'b0, "R3 clear");
    rd_reg(BASE + 0, '0, 1'b0, "R3 cleared");

    @(negedge clk);
    wr = 1'b1; addr = BASE + 1; wdata = '0; evt = B9;
    @(negedge clk);
    wr = 1'b0; evt = '0;
    rd_reg(BASE + 0, B9, 1'b0, "R3 event wins");

    wr_reg(3'd0, 64'hA5A5_0000_0000_0101);
    rd_reg(BASE + 0, 64'hA5A5_0000_0000_0101, 1'b0, "R4 load");
    wr_reg(3'd0, B9);

    wr_reg(3'd5, B9);
    chk_attn(1'b0, 1'b0, "R5 or-set");
    rd_reg(BASE + 3, B9, 1'b0, "R5 or read");
    wr_reg(3'd2, ~B9);
    chk_attn(1'b1, 1'b0, "R5 and-clear");

    rd_reg(BASE + 1, '0, 1'b1, "R10 off1");
    rd_reg(BASE + 2, '0, 1'b1, "R10 off2");
    rd_reg(BASE + 4, '0, 1'b1, "R10 off4");
    rd_reg(BASE + 5, '0, 1'b1, "R10 off5");
    rd_reg(16'h1000, '0, 1'b1, "R10 outside");

    @(negedge clk);
    issue_rd(BASE + 0, B9, 1'b0, "R11 first");
    @(negedge clk);
    issue_rd(BASE + 1, '0, 1'b1, "R11 second");
    @(negedge clk);
    issue_rd(BASE + 3, '0, 1'b0, "R11 third");
    @(negedge clk);
    rd = 1'b0;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule